// File: doc/BRIEF.md
# Per-Chip Write Power Token Allocator

This block decides when a write may begin its high-current cell update phase in a rank of memory chips whose supply can carry only a limited number of concurrent bit writes per chip. Every chip has its own pool of tokens, one token per bit write the chip can power at a time. A candidate write names its target bank and gives, per chip, how many bits it will change. It is admitted only when every chip has enough tokens for its share. On admission the shares are taken from the pools, and they are given back once the fixed array write time has passed.

Several candidates are presented at once. A candidate that does not fit is passed over and the lowest-numbered candidate that fits is granted, so a write that is short on one chip does not hold back the others. Each bank has one tracking slot, and each slot is a small state machine. In SLOT_FREE the slot holds no tokens. The transition *issue* moves it to SLOT_ARMED, where it counts down the write time. The transition *trim* moves SLOT_ARMED to SLOT_TRIMMED when the chips report a smaller actual bit count: the excess tokens go back to the pools at once. The transition *expire* moves SLOT_ARMED or SLOT_TRIMMED back to SLOT_FREE and returns what the slot still holds. Tokens being returned in a cycle count towards admissions in that same cycle.

Top module: `pwr_token_alloc`

## Requirements
- R1: After reset every chip pool holds TOK_MAX tokens, every slot is free and no grant is raised.
- R2: `grant_valid` rises combinationally in the cycle a candidate fits. A candidate fits when it is valid, its bank slot is free, and for every chip its need is no greater than the chip's available tokens. A need equal to the available tokens fits.
- R3: A candidate whose total need is covered by the sum of all pools, but which needs more than one chip has available, is not granted.
- R4: On the clock edge that ends a grant cycle, each chip's pool drops by the granted write's need for that chip.
- R5: Tokens reserved at the edge after a grant come back WRITE_LAT edges later. The pool level rises on that edge.
- R6: Among fitting candidates the lowest index is granted, and it is presented on `grant_idx`. Non-fitting candidates at lower indices are skipped.
- R7: Tokens returning in a cycle are counted as available in that cycle's admission decision.
- R8: With RELEASE_EN set, a report for an armed slot returns at the next edge, per chip, the reserved count minus the reported count (zero where the report is not smaller). The slot then holds the reduced count until it expires.
- R9: A report for a free slot, or for a slot that has already been trimmed, leaves every pool unchanged.
- R10: A candidate whose bank slot is busy is not granted, even when its need is zero.
- R11: A write with zero need on every chip is granted when the pools are empty. Any non-zero need on an empty chip stalls.
- R12: For each chip, the pool level plus the tokens held by all slots always equals TOK_MAX. No pool ever exceeds TOK_MAX or goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | NUM_CAND | One valid bit per candidate write |
| cand_need | input | NUM_CAND*NUM_CHIPS*CW | Per-candidate, per-chip changed-bit counts; chip c of candidate k at bits [(k*NUM_CHIPS+c)*CW +: CW] |
| cand_bank | input | NUM_CAND*BW | Target bank (slot) of each candidate |
| rel_valid | input | 1 | Actual-count report strobe |
| rel_bank | input | BW | Bank the report refers to |
| rel_actual | input | NUM_CHIPS*CW | Reported actual per-chip changed-bit counts, chip c at [c*CW +: CW] |
| grant_valid | output | 1 | A candidate is admitted this cycle |
| grant_idx | output | IW | Index of the admitted candidate |
| pool_level | output | NUM_CHIPS*CW | Registered token pool level per chip, chip c at [c*CW +: CW] |

## Verification
Two functions can fall in the same cycle: the *expire* transition of one slot and a new admission. They can also meet with a trim report. The bench steers a waiting candidate whose need on one chip equals that chip's pool plus the tokens coming back in the very cycle an earlier write expires. It then judges that the grant appears in that cycle and that the pool after the edge equals the old level plus the return minus the new need. A trim that comes after an earlier trim, and one aimed at a free bank, are judged by pool levels that do not move.

// File: rtl/tok_pkg.sv
package tok_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE    = 2'd0,
        SLOT_ARMED   = 2'd1,
        SLOT_TRIMMED = 2'd2
    } slot_state_e;
endpackage

// File: rtl/tok_slot.sv
module tok_slot
    import tok_pkg::*;
#(
    parameter int NUM_CHIPS  = 8,
    parameter int CW         = 3,
    parameter int WRITE_LAT  = 16,
    parameter bit RELEASE_EN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NUM_CHIPS*CW-1:0] load_need,
    input  logic                    rel_hit,
    input  logic [NUM_CHIPS*CW-1:0] rel_actual,
    output logic                    busy,
    output logic [NUM_CHIPS*CW-1:0] ret_vec,
    output logic [NUM_CHIPS*CW-1:0] refund_vec,
    output logic [NUM_CHIPS*CW-1:0] held_vec
);
    localparam int TW = $clog2(WRITE_LAT + 1);

    slot_state_e             state_q, state_d;
    logic [TW-1:0]           timer_q;
    logic [NUM_CHIPS*CW-1:0] held_q;
    logic                    expiring;
    logic                    take_rel;

    assign expiring = (state_q != SLOT_FREE) && (timer_q == TW'(1));

    generate
        if (RELEASE_EN) begin : g_rel
            assign take_rel = rel_hit && (state_q == SLOT_ARMED) && !expiring;
        end else begin : g_norel
            assign take_rel = 1'b0;
        end
    endgenerate

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:    if (load) state_d = SLOT_ARMED;
            SLOT_ARMED:   if (expiring) state_d = SLOT_FREE;
                          else if (take_rel) state_d = SLOT_TRIMMED;
            SLOT_TRIMMED: if (expiring) state_d = SLOT_FREE;
            default:      state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy = (state_q != SLOT_FREE);
        held_vec = held_q;
        ret_vec = expiring ? held_q : '0;
        refund_vec = '0;
        for (int c = 0; c < NUM_CHIPS; c++) begin
            if (take_rel && (held_q[c*CW +: CW] > rel_actual[c*CW +: CW]))
                refund_vec[c*CW +: CW] = held_q[c*CW +: CW] - rel_actual[c*CW +: CW];
        end
    end

    // timer and reservation data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            held_q  <= '0;
        end else begin
            if (load && state_q == SLOT_FREE) begin
                timer_q <= TW'(WRITE_LAT);
                held_q  <= load_need;
            end else begin
                if (state_q != SLOT_FREE) timer_q <= timer_q - TW'(1);
                if (expiring)      held_q <= '0;
                else if (take_rel) held_q <= held_q - refund_vec;
            end
        end
    end

    // R2
    load_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == SLOT_FREE));
    // R5
    expire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expiring |=> (state_q == SLOT_FREE));
    // R9
    trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_TRIMMED) |=> ($stable(held_q) || state_q == SLOT_FREE));
endmodule

// File: rtl/tok_pool.sv
module tok_pool #(
    parameter int NUM_CHIPS = 8,
    parameter int TOK_MAX   = 4,
    parameter int CW        = 3,
    parameter int SW        = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CHIPS*SW-1:0] ret_sum,
    input  logic [NUM_CHIPS*SW-1:0] refund_sum,
    input  logic                    take,
    input  logic [NUM_CHIPS*CW-1:0] take_need,
    output logic [NUM_CHIPS*SW-1:0] avail,
    output logic [NUM_CHIPS*CW-1:0] level
);
    logic [NUM_CHIPS*CW-1:0] level_q, level_d;
    logic                    short_any;

    always_comb begin
        short_any = 1'b0;
        for (int c = 0; c < NUM_CHIPS; c++) begin
            logic [SW-1:0] a, nxt;
            a   = SW'(level_q[c*CW +: CW]) + ret_sum[c*SW +: SW] + refund_sum[c*SW +: SW];
            nxt = a - (take ? SW'(take_need[c*CW +: CW]) : SW'(0));
            avail[c*SW +: SW]   = a;
            level_d[c*CW +: CW] = nxt[CW-1:0];
            if (take && SW'(take_need[c*CW +: CW]) > a) short_any = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CHIPS; c++) level_q[c*CW +: CW] <= CW'(TOK_MAX);
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;

    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) !short_any);

    generate
        for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_cap
            // R12
            pool_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                level_q[c*CW +: CW] <= CW'(TOK_MAX));
        end
    endgenerate
endmodule

// File: rtl/tok_arbiter.sv
module tok_arbiter #(
    parameter int NUM_CHIPS = 8,
    parameter int NUM_CAND  = 4,
    parameter int NUM_SLOTS = 8,
    parameter int CW        = 3,
    parameter int SW        = 7,
    parameter int BW        = 3,
    parameter int IW        = 2
) (
    input  logic [NUM_CAND-1:0]             cand_valid,
    input  logic [NUM_CAND*NUM_CHIPS*CW-1:0] cand_need,
    input  logic [NUM_CAND*BW-1:0]          cand_bank,
    input  logic [NUM_SLOTS-1:0]            slot_busy,
    input  logic [NUM_CHIPS*SW-1:0]         avail,
    output logic                            grant_valid,
    output logic [IW-1:0]                   grant_idx,
    output logic [NUM_CHIPS*CW-1:0]         grant_need,
    output logic [BW-1:0]                   grant_bank
);
    localparam int NW = NUM_CHIPS * CW;

    logic [NUM_CAND-1:0] fits;

    always_comb begin
        for (int k = 0; k < NUM_CAND; k++) begin
            logic ok;
            logic [BW-1:0] b;
            b  = cand_bank[k*BW +: BW];
            ok = cand_valid[k] && (int'(b) < NUM_SLOTS) && !slot_busy[b];
            for (int c = 0; c < NUM_CHIPS; c++) begin
                if (SW'(cand_need[k*NW + c*CW +: CW]) > avail[c*SW +: SW]) ok = 1'b0;
            end
            fits[k] = ok;
        end
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int k = NUM_CAND - 1; k >= 0; k--) begin
            if (fits[k]) begin
                grant_valid = 1'b1;
                grant_idx   = IW'(k);
            end
        end
        grant_need = cand_need[grant_idx*NW +: NW];
        grant_bank = cand_bank[grant_idx*BW +: BW];
    end
endmodule

// File: rtl/pwr_token_alloc.sv
module pwr_token_alloc #(
    parameter int NUM_CHIPS  = 8,
    parameter int TOK_MAX    = 4,
    parameter int NUM_CAND   = 4,
    parameter int NUM_SLOTS  = 8,
    parameter int WRITE_LAT  = 16,
    parameter bit RELEASE_EN = 1'b1,
    localparam int CW = $clog2(TOK_MAX + 1),
    localparam int BW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int IW = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CAND-1:0]              cand_valid,
    input  logic [NUM_CAND*NUM_CHIPS*CW-1:0] cand_need,
    input  logic [NUM_CAND*BW-1:0]           cand_bank,
    input  logic                             rel_valid,
    input  logic [BW-1:0]                    rel_bank,
    input  logic [NUM_CHIPS*CW-1:0]          rel_actual,
    output logic                             grant_valid,
    output logic [IW-1:0]                    grant_idx,
    output logic [NUM_CHIPS*CW-1:0]          pool_level
);
    localparam int SW = CW + $clog2(NUM_SLOTS + 1) + 1;
    localparam int NW = NUM_CHIPS * CW;

    logic [NUM_SLOTS-1:0]    slot_busy;
    logic [NUM_SLOTS*NW-1:0] slot_ret, slot_refund, slot_held;
    logic [NUM_CHIPS*SW-1:0] ret_sum, refund_sum, held_sum, avail;
    logic [NW-1:0]           grant_need;
    logic [BW-1:0]           grant_bank;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            tok_slot #(
                .NUM_CHIPS(NUM_CHIPS), .CW(CW),
                .WRITE_LAT(WRITE_LAT), .RELEASE_EN(RELEASE_EN)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (grant_valid && grant_bank == BW'(s)),
                .load_need  (grant_need),
                .rel_hit    (rel_valid && rel_bank == BW'(s)),
                .rel_actual (rel_actual),
                .busy       (slot_busy[s]),
                .ret_vec    (slot_ret[s*NW +: NW]),
                .refund_vec (slot_refund[s*NW +: NW]),
                .held_vec   (slot_held[s*NW +: NW])
            );
        end
    endgenerate

    always_comb begin
        ret_sum = '0;
        refund_sum = '0;
        held_sum = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int c = 0; c < NUM_CHIPS; c++) begin
                ret_sum[c*SW +: SW]    = ret_sum[c*SW +: SW]    + SW'(slot_ret[s*NW + c*CW +: CW]);
                refund_sum[c*SW +: SW] = refund_sum[c*SW +: SW] + SW'(slot_refund[s*NW + c*CW +: CW]);
                held_sum[c*SW +: SW]   = held_sum[c*SW +: SW]   + SW'(slot_held[s*NW + c*CW +: CW]);
            end
        end
    end

    tok_pool #(
        .NUM_CHIPS(NUM_CHIPS), .TOK_MAX(TOK_MAX), .CW(CW), .SW(SW)
    ) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_sum    (ret_sum),
        .refund_sum (refund_sum),
        .take       (grant_valid),
        .take_need  (grant_need),
        .avail      (avail),
        .level      (pool_level)
    );

    tok_arbiter #(
        .NUM_CHIPS(NUM_CHIPS), .NUM_CAND(NUM_CAND), .NUM_SLOTS(NUM_SLOTS),
        .CW(CW), .SW(SW), .BW(BW), .IW(IW)
    ) u_arb (
        .cand_valid  (cand_valid),
        .cand_need   (cand_need),
        .cand_bank   (cand_bank),
        .slot_busy   (slot_busy),
        .avail       (avail),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_need  (grant_need),
        .grant_bank  (grant_bank)
    );

    logic conserve_ok;
    always_comb begin
        conserve_ok = 1'b1;
        for (int c = 0; c < NUM_CHIPS; c++) begin
            if (SW'(pool_level[c*CW +: CW]) + held_sum[c*SW +: SW] != SW'(TOK_MAX))
                conserve_ok = 1'b0;
        end
    end

    // R12
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n) conserve_ok);
    // R6
    grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> cand_valid[grant_idx]);
    // R10
    grant_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> slot_busy[$past(grant_bank)]);
endmodule

// File: tb/pwr_token_alloc_test.sv
`timescale 1ns/1ps
module pwr_token_alloc_test;
    localparam int NC = 8, TM = 4, NCAND = 4, NS = 8, LAT = 6;
    localparam int CW = 3, BW = 3, IW = 2, NW = NC * CW;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NCAND-1:0]      cand_valid;
    logic [NCAND*NW-1:0]   cand_need;
    logic [NCAND*BW-1:0]   cand_bank;
    logic                  rel_valid;
    logic [BW-1:0]         rel_bank;
    logic [NW-1:0]         rel_actual;
    logic                  grant_valid;
    logic [IW-1:0]         grant_idx;
    logic [NW-1:0]         pool_level;

    always #2.5 clk = ~clk;

    pwr_token_alloc #(
        .NUM_CHIPS(NC), .TOK_MAX(TM), .NUM_CAND(NCAND), .NUM_SLOTS(NS),
        .WRITE_LAT(LAT), .RELEASE_EN(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_need(cand_need),
        .cand_bank(cand_bank), .rel_valid(rel_valid), .rel_bank(rel_bank),
        .rel_actual(rel_actual), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .pool_level(pool_level)
    );

    typedef struct {
        string       tag;
        logic        g;
        logic [IW-1:0] idx;
        logic [31:0] pools;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    // chip c count in hex nibble c
    function automatic logic [NW-1:0] pk(input logic [31:0] h);
        logic [NW-1:0] r;
        for (int c = 0; c < NC; c++) r[c*CW +: CW] = h[c*4 +: CW];
        return r;
    endfunction

    function automatic logic [31:0] unpk(input logic [NW-1:0] v);
        logic [31:0] r = '0;
        for (int c = 0; c < NC; c++) r[c*4 +: 4] = {1'b0, v[c*CW +: CW]};
        return r;
    endfunction

    task automatic clear_in();
        cand_valid = '0; cand_need = '0; cand_bank = '0;
        rel_valid = 1'b0; rel_bank = '0; rel_actual = '0;
    endtask

    task automatic set_cand(input int k, input logic [31:0] need, input int bank);
        cand_valid[k] = 1'b1;
        cand_need[k*NW +: NW] = pk(need);
        cand_bank[k*BW +: BW] = BW'(bank);
    endtask

    task automatic set_rel(input int bank, input logic [31:0] act);
        rel_valid = 1'b1; rel_bank = BW'(bank); rel_actual = pk(act);
    endtask

    // driver side: push expectation for the current cycle
    task automatic expect_now(input string tag, input logic g, input int idx, input logic [31:0] pools);
        exp_t e;
        #1;
        e.tag = tag; e.g = g; e.idx = IW'(idx); e.pools = pools;
        exp_q.push_back(e);
    endtask

    // monitor: pop and compare away from the clock edge
    always @(negedge clk) begin
        #2;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (grant_valid !== e.g || (e.g && grant_idx !== e.idx) || unpk(pool_level) !== e.pools) begin
                fails++;
                $display("FAIL %s: grant=%0b idx=%0d pools=%h expected grant=%0b idx=%0d pools=%h",
                         e.tag, grant_valid, grant_idx, unpk(pool_level), e.g, e.idx, e.pools);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_in();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // c0 reset state
        expect_now("R1 reset", 1'b0, 0, 32'h44444444);
        // c1 first write fits
        @(negedge clk); clear_in();
        set_cand(0, 32'h23201230, 1);
        expect_now("R2 grant", 1'b1, 0, 32'h44444444);
        // c2 cand0 short on chip2 only, cand1 fits
        @(negedge clk); clear_in();
        set_cand(0, 32'h00001301, 0);
        set_cand(1, 32'h10112112, 3);
        expect_now("R4 R3 R6 deduct/stall/skip", 1'b1, 1, 32'h21243214);
        // c3 still short; zero-need to busy bank
        @(negedge clk); clear_in();
        set_cand(0, 32'h00001301, 0);
        set_cand(1, 32'h00000000, 1);
        expect_now("R3 R10 stall", 1'b0, 0, 32'h11131102);
        // c4 trim bank 3
        @(negedge clk); clear_in();
        set_rel(3, 32'h10111111);
        expect_now("R4 before trim", 1'b0, 0, 32'h11131102);
        // c5 second report for trimmed bank
        @(negedge clk); clear_in();
        set_rel(3, 32'h00000000);
        expect_now("R8 refund", 1'b0, 0, 32'h11132103);
        // c6 report for a free bank
        @(negedge clk); clear_in();
        set_rel(5, 32'h00000000);
        expect_now("R9 trimmed report ignored", 1'b0, 0, 32'h11132103);
        // c7 first write returns; Y needs exactly what comes back on chip2
        @(negedge clk); clear_in();
        set_cand(0, 32'h00001301, 0);
        expect_now("R7 R9 same-cycle return", 1'b1, 0, 32'h11132103);
        // c8 second write (trimmed) returns
        @(negedge clk); clear_in();
        expect_now("R5 first return", 1'b0, 0, 32'h34332032);
        // c9
        @(negedge clk); clear_in();
        expect_now("R5 R8 trimmed return", 1'b0, 0, 32'h44443143);
        for (int i = 0; i < 4; i++) @(negedge clk);
        // c14 all back
        @(negedge clk); clear_in();
        expect_now("R5 R12 full pools", 1'b0, 0, 32'h44444444);
        // c15 take everything
        @(negedge clk); clear_in();
        set_cand(2, 32'h44444444, 2);
        expect_now("R2 full need", 1'b1, 2, 32'h44444444);
        // c16 empty pools, zero need
        @(negedge clk); clear_in();
        set_cand(0, 32'h00000001, 5);
        set_cand(3, 32'h00000000, 4);
        expect_now("R11 R12 empty pools", 1'b1, 3, 32'h00000000);
        // c17 non-zero need on empty chip
        @(negedge clk); clear_in();
        set_cand(0, 32'h00000001, 5);
        expect_now("R11 stall on empty", 1'b0, 0, 32'h00000000);
        @(negedge clk); clear_in();
        #3;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule